// File: doc/BRIEF.md
# Ethernet Event Statistics Counter Bank

This block keeps a set of 32-bit event counters for an Ethernet MAC. The MAC datapath raises one increment strobe per counter for each event it sees. Software reaches the counters through a word-addressed register port. A read returns the selected count one cycle later. What a write does depends on a mode input. In subtract mode, the written value is taken off the count and the result stops at zero. In load mode, the written value replaces the count. Every count wraps to zero when it passes its maximum.

After reset is released, a small controller waits a fixed number of clocks before it wipes the whole bank in a single cycle. It walks through three named states:
- `ST_COUNTDOWN` is entered whenever `rst` is high. It is left on the transition "delay reached", taken on the 37th rising edge after `rst` falls, towards `ST_WIPE`.
- `ST_WIPE` zeroes every counter on the next edge. Its transition "wipe done" leads to `ST_RUN`.
- `ST_RUN` holds until the next reset. Only this state drops `busy` and lets host accesses through.

A shared interrupt line is raised while its enable is high and any counter has its most significant bit set. Software clears that condition by subtracting from the counters concerned.

Top module: `netstat_bank`

## Requirements
- R1: While `rst` is high, and for the first 37 rising edges after it falls, `busy` reads 1. On the 38th edge `busy` drops to 0 and every counter becomes zero.
- R2: While `busy` is 1, host writes change no counter and `rd_data` reads zero.
- R3: Each cycle in which a counter's strobe bit in `inc_strobe` is high adds one to that counter. FFFF_FFFFh steps to 0000_0000h.
- R4: With `dec_mode` = 0, an accepted write stores `host_wdata` into the counter at word address `host_addr`.
- R5: With `dec_mode` = 1, an accepted write stores the counter value minus `host_wdata`.
- R6: In subtract mode, a written value larger than or equal to the count leaves zero, so writing FFFF_FFFFh always clears.
- R7: When an accepted write and that counter's strobe fall in the same cycle, the counter takes the write result plus one, in either mode.
- R8: A write is accepted only when `host_be` is 4'hF. Any other byte-enable pattern leaves every counter unchanged.
- R9: `rd_data` shows, one edge after `host_addr` is presented, the value the addressed counter held before that edge. Addresses at or above the counter count read zero.
- R10: `irq` is high, with no clock delay, exactly when `irq_en` is 1, `busy` is 0 and some counter is at or above 8000_0000h. A subtract write that brings the count below that drops it.
- R11: With `irq_en` = 0, `irq` stays low whatever the counters hold.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| dec_mode | input | 1 | 1: writes subtract with a floor at zero; 0: writes load |
| irq_en | input | 1 | Enable for the shared interrupt |
| host_addr | input | ADDR_W (5) | Word address of the selected counter |
| host_wr | input | 1 | Write strobe for one cycle |
| host_be | input | 4 | Byte enables; only 4'hF makes a write valid |
| host_wdata | input | 32 | Write value |
| inc_strobe | input | NUM_CTR (8) | One increment strobe per counter |
| rd_data | output | 32 | Registered read data |
| busy | output | 1 | High until the post-reset wipe has completed |
| irq | output | 1 | Statistics interrupt |

## Verification
Counter updates, `busy` and `rd_data` all move on the rising edge that samples the stimulus. A read therefore shows the pre-edge count one edge after the address. A write or strobe becomes visible to a read presented on the following edge. `irq` follows the counters and `irq_en` combinationally, so it is valid within the same cycle as the counter change. The bench drives inputs 2 ns after each rising edge. A behavioural model updates on the same edge, and `busy`, `rd_data` and `irq` are compared at the falling edge, where all of them have settled. Directed checks with literal expected values are taken after the edge on which the result is due.

// File: rtl/stat_pkg.sv
package stat_pkg;

    typedef enum logic [1:0] {
        ST_COUNTDOWN = 2'd0,
        ST_WIPE      = 2'd1,
        ST_RUN       = 2'd2
    } clr_state_e;

    localparam int unsigned STAT_W  = 32;
    localparam int unsigned BE_W    = STAT_W / 8;

endpackage

// File: rtl/stat_clear_fsm.sv
module stat_clear_fsm
    import stat_pkg::*;
#(
    parameter int unsigned CLEAR_DELAY = 38
) (
    input  logic clk,
    input  logic rst,
    output logic busy,
    output logic wipe
);

    localparam int unsigned DW = $clog2(CLEAR_DELAY + 1);
    localparam logic [DW-1:0] LAST_WAIT = DW'(CLEAR_DELAY - 2);

    clr_state_e     state_q;
    clr_state_e     state_d;
    logic [DW-1:0]  dly_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_COUNTDOWN;
        end else begin
            state_q <= state_d;
        end
    end

    // delay counter, only runs while waiting
    always_ff @(posedge clk) begin
        if (rst) begin
            dly_q <= '0;
        end else if (state_q == ST_COUNTDOWN) begin
            dly_q <= dly_q + 1'b1;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_COUNTDOWN: if (dly_q == LAST_WAIT) state_d = ST_WIPE;
            ST_WIPE:      state_d = ST_RUN;
            ST_RUN:       state_d = ST_RUN;
            default:      state_d = ST_COUNTDOWN;
        endcase
    end

    // outputs
    always_comb begin
        busy = 1'b1;
        wipe = 1'b0;
        unique case (state_q)
            ST_COUNTDOWN: begin busy = 1'b1; wipe = 1'b0; end
            ST_WIPE:      begin busy = 1'b1; wipe = 1'b1; end
            ST_RUN:       begin busy = 1'b0; wipe = 1'b0; end
            default:      begin busy = 1'b1; wipe = 1'b0; end
        endcase
    end

endmodule

// File: rtl/stat_ctr_cell.sv
module stat_ctr_cell #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         wipe,
    input  logic         wr_hit,
    input  logic         dec_mode,
    input  logic [W-1:0] wr_data,
    input  logic         inc,
    output logic [W-1:0] count
);

    logic [W-1:0] base;
    logic [W-1:0] floored;

    // subtraction that stops at zero
    always_comb begin
        if (count > wr_data) begin
            floored = count - wr_data;
        end else begin
            floored = '0;
        end
    end

    always_comb begin
        if (wr_hit) begin
            base = dec_mode ? floored : wr_data;
        end else begin
            base = count;
        end
    end

    // no reset: the bank is wiped by the clear sequencer
    always_ff @(posedge clk) begin
        if (wipe) begin
            count <= '0;
        end else begin
            count <= base + {{(W-1){1'b0}}, inc};
        end
    end

endmodule

// File: rtl/stat_readback.sv
module stat_readback #(
    parameter int unsigned N  = 8,
    parameter int unsigned W  = 32,
    parameter int unsigned AW = 5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                busy,
    input  logic [AW-1:0]       addr,
    input  logic [N-1:0][W-1:0] cnt,
    input  logic                irq_en,
    output logic [W-1:0]        rd_data,
    output logic                irq
);

    logic [W-1:0] sel;
    logic         any_high;

    always_comb begin
        sel = '0;
        for (int i = 0; i < N; i++) begin
            if (addr == AW'(i)) sel = cnt[i];
        end
    end

    always_comb begin
        any_high = 1'b0;
        for (int i = 0; i < N; i++) begin
            any_high = any_high | cnt[i][W-1];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (busy) begin
            rd_data <= '0;
        end else begin
            rd_data <= sel;
        end
    end

    assign irq = irq_en & ~busy & any_high;

endmodule

// File: rtl/netstat_bank.sv
module netstat_bank
    import stat_pkg::*;
#(
    parameter int unsigned NUM_CTR     = 8,
    parameter int unsigned ADDR_W      = 5,
    parameter int unsigned CLEAR_DELAY = 38
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 dec_mode,
    input  logic                 irq_en,
    input  logic [ADDR_W-1:0]    host_addr,
    input  logic                 host_wr,
    input  logic [BE_W-1:0]      host_be,
    input  logic [STAT_W-1:0]    host_wdata,
    input  logic [NUM_CTR-1:0]   inc_strobe,
    output logic [STAT_W-1:0]    rd_data,
    output logic                 busy,
    output logic                 irq
);

    logic                             wipe;
    logic                             wr_ok;
    logic [NUM_CTR-1:0]               hit;
    logic [NUM_CTR-1:0][STAT_W-1:0]   cnt_q;

    stat_clear_fsm #(.CLEAR_DELAY(CLEAR_DELAY)) u_clr (
        .clk  (clk),
        .rst  (rst),
        .busy (busy),
        .wipe (wipe)
    );

    assign wr_ok = host_wr & (host_be == {BE_W{1'b1}}) & ~busy;

    for (genvar g = 0; g < NUM_CTR; g++) begin : g_ctr
        assign hit[g] = wr_ok & (host_addr == ADDR_W'(g));

        stat_ctr_cell #(.W(STAT_W)) u_cell (
            .clk      (clk),
            .wipe     (wipe),
            .wr_hit   (hit[g]),
            .dec_mode (dec_mode),
            .wr_data  (host_wdata),
            .inc      (inc_strobe[g]),
            .count    (cnt_q[g])
        );
    end

    stat_readback #(.N(NUM_CTR), .W(STAT_W), .AW(ADDR_W)) u_rb (
        .clk     (clk),
        .rst     (rst),
        .busy    (busy),
        .addr    (host_addr),
        .cnt     (cnt_q),
        .irq_en  (irq_en),
        .rd_data (rd_data),
        .irq     (irq)
    );

endmodule

// File: rtl/stat_bank_chk.sv
module stat_bank_chk #(
    parameter int unsigned NUM_CTR = 8,
    parameter int unsigned ADDR_W  = 5
) (
    input logic               clk,
    input logic               rst,
    input logic               busy,
    input logic               dec_mode,
    input logic               irq_en,
    input logic [ADDR_W-1:0]  host_addr,
    input logic               host_wr,
    input logic [3:0]         host_be,
    input logic [31:0]        host_wdata,
    input logic               inc0,
    input logic [31:0]        cnt0,
    input logic [31:0]        rd_data,
    input logic               irq
);

    logic acc0;
    assign acc0 = host_wr && (host_be == 4'hF) && !busy && (host_addr == '0);

    // R1
    reset_busy_chk: assert property (@(posedge clk) rst |=> busy);

    // R2
    busy_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (rd_data == 32'h0));

    // R3
    wrap_chk: assert property (@(posedge clk) disable iff (rst || busy)
        (!acc0 && inc0 && cnt0 == 32'hFFFF_FFFF) |=> (cnt0 == 32'h0));

    // R6
    floor_chk: assert property (@(posedge clk) disable iff (rst || busy)
        (acc0 && dec_mode && !inc0) |=>
        (cnt0 == (($past(cnt0) > $past(host_wdata)) ? ($past(cnt0) - $past(host_wdata)) : 32'h0)));

    // R7
    load_plus_inc_chk: assert property (@(posedge clk) disable iff (rst || busy)
        (acc0 && !dec_mode && inc0) |=> (cnt0 == $past(host_wdata) + 32'h1));

    // R8
    partial_be_chk: assert property (@(posedge clk) disable iff (rst || busy)
        (host_wr && host_be != 4'hF && !inc0) |=> $stable(cnt0));

    // R9
    unused_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (int'(host_addr) >= NUM_CTR) |=> (rd_data == 32'h0));

    // R10
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst || busy)
        (irq_en && cnt0[31]) |-> irq);

    // R11
    irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq);

endmodule

bind netstat_bank stat_bank_chk #(.NUM_CTR(NUM_CTR), .ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .busy       (busy),
    .dec_mode   (dec_mode),
    .irq_en     (irq_en),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_be    (host_be),
    .host_wdata (host_wdata),
    .inc0       (inc_strobe[0]),
    .cnt0       (cnt_q[0]),
    .rd_data    (rd_data),
    .irq        (irq)
);

// File: tb/tb_netstat_bank.sv
module tb_netstat_bank;

    localparam int NUM = 8;
    localparam int AW  = 5;
    localparam int DLY = 38;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            dec_mode = 1'b0;
    logic            irq_en = 1'b0;
    logic [AW-1:0]   host_addr = '0;
    logic            host_wr = 1'b0;
    logic [3:0]      host_be = 4'hF;
    logic [31:0]     host_wdata = '0;
    logic [NUM-1:0]  inc_strobe = '0;
    logic [31:0]     rd_data;
    logic            busy;
    logic            irq;

    always #5 clk = ~clk;

    netstat_bank #(.NUM_CTR(NUM), .ADDR_W(AW), .CLEAR_DELAY(DLY)) dut (
        .clk        (clk),
        .rst        (rst),
        .dec_mode   (dec_mode),
        .irq_en     (irq_en),
        .host_addr  (host_addr),
        .host_wr    (host_wr),
        .host_be    (host_be),
        .host_wdata (host_wdata),
        .inc_strobe (inc_strobe),
        .rd_data    (rd_data),
        .busy       (busy),
        .irq        (irq)
    );

    int    n_chk  = 0;
    int    n_fail = 0;
    string cur_req = "R1";
    bit    chk_on = 1'b0;

    // reference model
    logic [31:0] m_cnt [NUM];
    int          m_left = DLY;
    bit          m_busy = 1'b1;
    logic [31:0] m_rd = '0;

    initial for (int i = 0; i < NUM; i++) m_cnt[i] = '0;

    always @(posedge clk) begin
        if (rst) begin
            m_left = DLY;
            m_busy = 1'b1;
            m_rd   = '0;
        end else begin
            m_rd = (m_busy || int'(host_addr) >= NUM) ? 32'h0 : m_cnt[host_addr];
            if (m_busy) begin
                if (m_left == 1) begin
                    for (int i = 0; i < NUM; i++) m_cnt[i] = '0;
                    m_busy = 1'b0;
                end
                m_left = m_left - 1;
            end else begin
                for (int i = 0; i < NUM; i++) begin
                    logic [31:0] v;
                    v = m_cnt[i];
                    if (host_wr && host_be == 4'hF && int'(host_addr) == i) begin
                        if (dec_mode) v = (v > host_wdata) ? v - host_wdata : 32'h0;
                        else          v = host_wdata;
                    end
                    v = v + {31'h0, inc_strobe[i]};
                    m_cnt[i] = v;
                end
            end
        end
    end

    function automatic logic m_irq();
        logic a;
        a = 1'b0;
        for (int i = 0; i < NUM; i++) a = a | m_cnt[i][31];
        return irq_en && !m_busy && a;
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (chk_on) begin
            chk({cur_req, " busy"}, {31'h0, busy}, {31'h0, m_busy});
            chk({cur_req, " rd_data"}, rd_data, m_rd);
            chk({cur_req, " irq"}, {31'h0, irq}, {31'h0, m_irq()});
        end
    end

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be = 4'hF);
        host_addr  = AW'(a);
        host_wdata = d;
        host_be    = be;
        host_wr    = 1'b1;
        cyc();
        host_wr    = 1'b0;
        host_be    = 4'hF;
    endtask

    task automatic rd(input int a);
        host_addr = AW'(a);
        cyc();
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        // R1: reset and delayed wipe
        cyc();
        chk_on = 1'b1;
        cyc();
        chk("R1", {31'h0, busy}, 32'h1);
        rst = 1'b0;
        repeat (10) cyc();
        // R2: write during the clear is dropped, reads give zero
        cur_req = "R2";
        wr(0, 32'h0000_0055);
        chk("R2", rd_data, 32'h0);
        repeat (DLY - 12) cyc();
        cur_req = "R1";
        chk("R1", {31'h0, busy}, 32'h1);
        cyc();
        chk("R1", {31'h0, busy}, 32'h0);
        rd(0);
        chk("R2", rd_data, 32'h0);
        rd(7);
        chk("R1", rd_data, 32'h0);

        // R3: increments and wrap
        cur_req = "R3";
        inc_strobe = 8'b0000_0010;
        repeat (3) cyc();
        inc_strobe = '0;
        rd(1);
        chk("R3", rd_data, 32'h3);
        wr(2, 32'hFFFF_FFFE);
        inc_strobe = 8'b1000_0100;
        repeat (3) cyc();
        inc_strobe = '0;
        rd(2);
        chk("R3 wrap", rd_data, 32'h1);
        rd(7);
        chk("R3", rd_data, 32'h3);

        // R4: direct load
        cur_req = "R4";
        wr(4, 32'h1234_5678);
        rd(4);
        chk("R4", rd_data, 32'h1234_5678);

        // R5: subtract
        cur_req = "R5";
        dec_mode = 1'b1;
        wr(4, 32'h0000_0078);
        rd(4);
        chk("R5", rd_data, 32'h1234_5600);

        // R6: floor at zero
        cur_req = "R6";
        wr(4, 32'h2000_0000);
        rd(4);
        chk("R6", rd_data, 32'h0);
        dec_mode = 1'b0;
        wr(5, 32'h0000_0077);
        dec_mode = 1'b1;
        wr(5, 32'hFFFF_FFFF);
        rd(5);
        chk("R6 all-ones", rd_data, 32'h0);
        wr(1, 32'h0000_0003);
        rd(1);
        chk("R6 equal", rd_data, 32'h0);

        // R7: write and strobe together
        cur_req = "R7";
        dec_mode = 1'b0;
        inc_strobe = 8'b0100_0000;
        wr(6, 32'd100);
        inc_strobe = '0;
        rd(6);
        chk("R7 load", rd_data, 32'd101);
        dec_mode = 1'b1;
        inc_strobe = 8'b0100_0000;
        wr(6, 32'd1);
        inc_strobe = '0;
        rd(6);
        chk("R7 sub", rd_data, 32'd101);
        inc_strobe = 8'b0000_0001;
        wr(0, 32'd9);
        inc_strobe = '0;
        rd(0);
        chk("R7 floor", rd_data, 32'd1);

        // R8: partial byte enables
        cur_req = "R8";
        dec_mode = 1'b0;
        wr(6, 32'h0000_0055, 4'h7);
        wr(6, 32'h0000_0055, 4'h1);
        rd(6);
        chk("R8", rd_data, 32'd101);

        // R9: read latency and unused addresses
        cur_req = "R9";
        rd(20);
        chk("R9", rd_data, 32'h0);
        rd(NUM);
        chk("R9", rd_data, 32'h0);
        rd(31);
        chk("R9", rd_data, 32'h0);

        // R10: interrupt
        cur_req = "R10";
        irq_en = 1'b1;
        wr(3, 32'h8000_0000);
        chk("R10 set", {31'h0, irq}, 32'h1);
        dec_mode = 1'b1;
        wr(3, 32'h0000_0001);
        chk("R10 cleared", {31'h0, irq}, 32'h0);
        inc_strobe = 8'b0000_1000;
        cyc();
        inc_strobe = '0;
        chk("R10 by inc", {31'h0, irq}, 32'h1);

        // R11: mask
        cur_req = "R11";
        irq_en = 1'b0;
        #1;
        chk("R11", {31'h0, irq}, 32'h0);
        cyc();
        irq_en = 1'b1;
        #1;
        chk("R10 re-enable", {31'h0, irq}, 32'h1);
        wr(3, 32'hFFFF_FFFF);
        chk("R10 clear", {31'h0, irq}, 32'h0);
        dec_mode = 1'b0;

        // R1: reset during operation
        cur_req = "R1";
        rst = 1'b1;
        cyc();
        chk("R1 re-reset", {31'h0, busy}, 32'h1);
        rst = 1'b0;
        repeat (DLY) cyc();
        chk("R1 ready", {31'h0, busy}, 32'h0);
        rd(6);
        chk("R1 wiped", rd_data, 32'h0);
        cyc();

        summary();
        $finish;
    end

endmodule